// File: doc/BRIEF.md
# Dual-Mode Double-Buffered Converter Input Register

This block is the digital front end of a 16-bit digital-to-analog converter, modelled synchronously on a fast system clock. A first-rank holding word is filled either one bit at a time or one byte at a time. A level-sensitive load then copies that word into a second-rank register, which drives the converter code. All pin inputs pass through two-flop synchronisers. Strobe edges are found by comparing the current synchronised sample with the previous one.

When the mode pin is low, the block works in serial mode. Bus bit 0 carries the data bit and bus bit 1 selects the shift direction. Each rising strobe edge moves one bit into the holding word and presents the bit that leaves it on a serial output, so that several devices can be chained. When the mode pin is high, the block works in byte mode. The bus is written into the upper or lower half of the holding word while the strobe and the matching half enable are both high. A clear forces the output code to zero or to midscale and does not touch the holding word, so a later load brings the old word back.

Top module: `dac_front_end`

## Requirements
- R1: After reset the output code is 0x0000 and the serial output is 0.
- R2: In serial mode (`byte_mode`=0) with `data_bus[1]`=1, each rising edge of `strobe` shifts `data_bus[0]` into bit 0 and moves the other bits up by one, so the first of 16 bits lands in bit 15.
- R3: In serial mode with `data_bus[1]`=0, each rising edge of `strobe` shifts `data_bus[0]` into bit 15 and moves the other bits down by one, so the first of 16 bits lands in bit 0.
- R4: On each shift, `ser_out` takes the bit that leaves the holding word (bit 15 when shifting up, bit 0 when shifting down). It holds that value until the next rising edge of `strobe`.
- R5: In byte mode (`byte_mode`=1), while `strobe` is high, `hi_en`=1 writes `data_bus` into bits 15:8 and `lo_en`=1 writes it into bits 7:0. The two halves may be written in either order.
- R6: In serial mode, `hi_en` and `data_bus[7:2]` have no effect on the holding word.
- R7: While `load` is high and `clear` is low, the output code follows the holding word. While both are low, the output code holds its value.
- R8: While `clear` is high, the output code is 0x0000 if `lo_en`=0 and 0x8000 if `lo_en`=1. The holding word is unchanged, and a later load restores it.
- R9: When `clear` and `load` are both high, clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_mode | input | 1 | 1 = byte mode, 0 = serial mode |
| strobe | input | 1 | Chip-select strobe; its rising edge shifts in serial mode, its high level enables byte writes |
| hi_en | input | 1 | Upper-half write enable (byte mode only) |
| lo_en | input | 1 | Lower-half write enable in byte mode; selects the clear target in both modes |
| load | input | 1 | Level-sensitive copy of the holding word to the output |
| clear | input | 1 | Forces the output code to unipolar or bipolar zero |
| data_bus | input | 8 | Byte data; bit 0 is the serial data bit and bit 1 the direction in serial mode |
| ser_out | output | 1 | Bit shifted out of the holding word, used for chaining |
| dac_code | output | 16 | Code that drives the converter |

## Verification
The hardest state to reach is a holding word that still holds valid data while the output shows a cleared value. Only a following load exposes that the clear left the holding word untouched. The bench fills the word serially, loads it, asserts clear with `lo_en` at each level (once together with load), and then loads again with clear released, expecting the original word. Chaining is checked by shifting a second word behind the first and comparing `ser_out` after every strobe against the first word's bits in order.

// File: rtl/dacin_pkg.sv
package dacin_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  typedef enum logic { SHIFT_DOWN = 1'b0, SHIFT_UP = 1'b1 } shift_dir_e;
endpackage

// File: rtl/dacin_sync.sv
module dacin_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/dacin_first_rank.sv
module dacin_first_rank
  import dacin_pkg::*;
#(
  parameter int WORD_W_P = WORD_W,
  parameter int BYTE_W_P = BYTE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                byte_mode,
  input  logic                stb_level,
  input  logic                stb_rise,
  input  logic                hi_en,
  input  logic                lo_en,
  input  logic [BYTE_W_P-1:0] data,
  output logic [WORD_W_P-1:0] word_o,
  output logic                sout_o
);
  localparam int HALVES = WORD_W_P / BYTE_W_P;

  logic [WORD_W_P-1:0] word_q;
  logic                sout_q;
  logic [HALVES-1:0]   half_we;
  shift_dir_e          dir;
  logic                sin;

  assign sin = data[0];
  assign dir = shift_dir_e'(data[1]);

  // half 0 is the lower byte, the last half is the upper byte
  generate
    for (genvar h = 0; h < HALVES; h++) begin : g_we
      if (h == HALVES - 1) begin : g_hi
        assign half_we[h] = byte_mode && stb_level && hi_en;
      end else if (h == 0) begin : g_lo
        assign half_we[h] = byte_mode && stb_level && lo_en;
      end else begin : g_mid
        assign half_we[h] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      sout_q <= 1'b0;
    end else if (!byte_mode) begin
      if (stb_rise) begin
        if (dir == SHIFT_UP) begin
          sout_q <= word_q[WORD_W_P-1];
          word_q <= {word_q[WORD_W_P-2:0], sin};
        end else begin
          sout_q <= word_q[0];
          word_q <= {sin, word_q[WORD_W_P-1:1]};
        end
      end
    end else begin
      for (int h = 0; h < HALVES; h++) begin
        if (half_we[h]) word_q[h*BYTE_W_P +: BYTE_W_P] <= data;
      end
    end
  end

  assign word_o = word_q;
  assign sout_o = sout_q;

  // R2
  shift_up_chk: assert property (@(posedge clk) disable iff (rst)
    (!byte_mode && stb_rise && data[1]) |=> word_q[0] == $past(data[0]));
  // R3
  shift_down_chk: assert property (@(posedge clk) disable iff (rst)
    (!byte_mode && stb_rise && !data[1]) |=> word_q[WORD_W_P-1] == $past(data[0]));
  // R4
  sout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !stb_rise |=> $stable(sout_q));
  // R5
  hi_write_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_mode && stb_level && hi_en) |=> word_q[WORD_W_P-1 -: BYTE_W_P] == $past(data));
  // R6
  serial_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!byte_mode && !stb_rise) |=> $stable(word_q));
endmodule

// File: rtl/dacin_second_rank.sv
module dacin_second_rank #(
  parameter int WORD_W_P = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                clear,
  input  logic                bipolar,
  input  logic [WORD_W_P-1:0] first_word,
  output logic [WORD_W_P-1:0] code_o
);
  localparam logic [WORD_W_P-1:0] MID = {1'b1, {(WORD_W_P-1){1'b0}}};

  logic [WORD_W_P-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
    end else if (clear) begin
      code_q <= bipolar ? MID : '0;
    end else if (load) begin
      code_q <= first_word;
    end
  end

  assign code_o = code_q;

  // R8 R9
  clear_target_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> code_q == ($past(bipolar) ? MID : '0));
  // R7
  load_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !clear) |=> code_q == $past(first_word));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !clear) |=> $stable(code_q));
endmodule

// File: rtl/dac_front_end.sv
module dac_front_end
  import dacin_pkg::*;
#(
  parameter int WORD_W_P = WORD_W,
  parameter int BYTE_W_P = BYTE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                byte_mode,
  input  logic                strobe,
  input  logic                hi_en,
  input  logic                lo_en,
  input  logic                load,
  input  logic                clear,
  input  logic [BYTE_W_P-1:0] data_bus,
  output logic                ser_out,
  output logic [WORD_W_P-1:0] dac_code
);
  localparam int CTRL_W = 6;
  localparam int SYNC_W = CTRL_W + BYTE_W_P;

  logic [SYNC_W-1:0]   raw;
  logic [SYNC_W-1:0]   syn;
  logic                stb_prev_q;
  logic                stb_rise;
  logic [WORD_W_P-1:0] first_word;

  logic s_mode, s_stb, s_hi, s_lo, s_ld, s_clr;
  logic [BYTE_W_P-1:0] s_data;

  assign raw = {byte_mode, strobe, hi_en, lo_en, load, clear, data_bus};
  assign {s_mode, s_stb, s_hi, s_lo, s_ld, s_clr, s_data} = syn;

  dacin_sync #(.W(SYNC_W)) u_sync (
    .clk(clk), .rst(rst), .async_i(raw), .sync_o(syn)
  );

  always_ff @(posedge clk) begin
    if (rst) stb_prev_q <= 1'b0;
    else     stb_prev_q <= s_stb;
  end

  assign stb_rise = s_stb && !stb_prev_q;

  dacin_first_rank #(.WORD_W_P(WORD_W_P), .BYTE_W_P(BYTE_W_P)) u_first (
    .clk(clk), .rst(rst), .byte_mode(s_mode), .stb_level(s_stb),
    .stb_rise(stb_rise), .hi_en(s_hi), .lo_en(s_lo), .data(s_data),
    .word_o(first_word), .sout_o(ser_out)
  );

  dacin_second_rank #(.WORD_W_P(WORD_W_P)) u_second (
    .clk(clk), .rst(rst), .load(s_ld), .clear(s_clr), .bipolar(s_lo),
    .first_word(first_word), .code_o(dac_code)
  );

  // R1
  reset_code_chk: assert property (@(posedge clk)
    rst |=> (dac_code == '0 && ser_out == 1'b0));
endmodule

// File: tb/tb_dac_front_end.sv
module tb_dac_front_end;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_mode = 1'b0, strobe = 1'b0, hi_en = 1'b0, lo_en = 1'b0;
  logic load = 1'b0, clear = 1'b0;
  logic [7:0] data_bus = '0;
  logic ser_out;
  logic [15:0] dac_code;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  int    exp_q[$];
  int    kind_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_front_end dut (
    .clk(clk), .rst(rst), .byte_mode(byte_mode), .strobe(strobe),
    .hi_en(hi_en), .lo_en(lo_en), .load(load), .clear(clear),
    .data_bus(data_bus), .ser_out(ser_out), .dac_code(dac_code)
  );

  // monitor: pops expected items and compares them with the outputs
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      int e, k, a;
      string t;
      e = exp_q.pop_front();
      k = kind_q.pop_front();
      t = tag_q.pop_front();
      a = (k == 0) ? int'(dac_code) : int'(ser_out);
      checks++;
      if (a != e) begin
        failures++;
        $display("FAIL %s actual=0x%0h expected=0x%0h", t, a, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(int kind, int val, string tag);
    exp_q.push_back(val);
    kind_q.push_back(kind);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic pulse_strobe();
    strobe = 1'b1; idle(SETTLE);
    strobe = 1'b0; idle(SETTLE);
  endtask

  task automatic shift_bit(logic b, logic up);
    data_bus[0] = b;
    data_bus[1] = up;
    idle(2);
    pulse_strobe();
  endtask

  task automatic shift_word(logic [15:0] w, logic up);
    for (int i = 0; i < 16; i++) shift_bit(up ? w[15-i] : w[i], up);
  endtask

  task automatic pulse_load();
    load = 1'b1; idle(SETTLE);
    load = 1'b0; idle(SETTLE);
  endtask

  task automatic write_byte(logic hi, logic [7:0] v);
    data_bus = v; hi_en = hi; lo_en = !hi; idle(2);
    pulse_strobe();
    hi_en = 1'b0; lo_en = 1'b0; idle(2);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    idle(3);
    // R1
    expect_item(0, 16'h0000, "R1 reset code");
    expect_item(1, 0, "R1 reset ser_out");

    // R2 msb first
    shift_word(16'hA5C3, 1'b1);
    pulse_load();
    expect_item(0, 16'hA5C3, "R2 msb-first word");
    // R7 hold when load low
    data_bus = 8'h00; shift_bit(1'b1, 1'b1); idle(2);
    expect_item(0, 16'hA5C3, "R7 hold without load");

    // R4 chaining: push a new word, sout yields previous bits in order
    shift_word(16'h5A3C, 1'b1);
    pulse_load();
    expect_item(0, 16'h5A3C, "R2 second msb-first word");
    shift_bit(1'b0, 1'b1);
    expect_item(1, 0, "R4 ser_out first chained bit");
    idle(10);
    expect_item(1, 0, "R4 ser_out stable between strobes");
    for (int i = 1; i < 16; i++) begin
      shift_bit(1'b0, 1'b1);
      expect_item(1, int'(~i[0] ? 1'b0 : 1'b0) | int'(16'h5A3C >> (15 - i)) & 1, "R4 ser_out chained bit");
    end

    // R3 lsb first
    shift_word(16'h1E87, 1'b0);
    pulse_load();
    expect_item(0, 16'h1E87, "R3 lsb-first word");
    shift_bit(1'b0, 1'b0);
    expect_item(1, 1, "R4 ser_out lsb side");

    // R6 hi_en and upper bus bits ignored in serial mode
    hi_en = 1'b1;
    data_bus[7:2] = 6'b111111;
    for (int i = 0; i < 16; i++) begin
      data_bus[0] = (16'h0F0F >> (15 - i)) & 1;
      data_bus[1] = 1'b1;
      idle(2);
      pulse_strobe();
    end
    hi_en = 1'b0; data_bus = '0;
    pulse_load();
    expect_item(0, 16'h0F0F, "R6 serial ignores hi_en and upper bus");

    // R5 byte mode, high then low, then low then high
    byte_mode = 1'b1; idle(4);
    write_byte(1'b1, 8'h3C);
    write_byte(1'b0, 8'hD2);
    pulse_load();
    expect_item(0, 16'h3CD2, "R5 byte high then low");
    write_byte(1'b0, 8'h11);
    write_byte(1'b1, 8'hE4);
    pulse_load();
    expect_item(0, 16'hE411, "R5 byte low then high");

    // R8 clear to unipolar zero, first rank kept
    lo_en = 1'b0; clear = 1'b1; idle(SETTLE);
    expect_item(0, 16'h0000, "R8 unipolar clear");
    clear = 1'b0; idle(SETTLE);
    pulse_load();
    expect_item(0, 16'hE411, "R8 load restores after clear");
    // R8 bipolar clear
    lo_en = 1'b1; clear = 1'b1; idle(SETTLE);
    expect_item(0, 16'h8000, "R8 bipolar clear");
    // R9 clear beats load
    load = 1'b1; idle(SETTLE);
    expect_item(0, 16'h8000, "R9 clear over load");
    clear = 1'b0; lo_en = 1'b0; idle(SETTLE);
    expect_item(0, 16'hE411, "R7 load follows after clear drops");
    load = 1'b0; idle(SETTLE);

    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule